// File: doc/BRIEF.md
# Two-Channel Bitstream Decimator

This block turns two single-bit sigma-delta streams into signed 16-bit PCM words. Each input bit counts as +1 for a one and −1 for a zero. The rate falls by 64 in three linear-phase FIR stages, by 16, then 2, then 2. The first stage is a fourth-order comb filter built in recursive form: four integrators followed by four differencers. The second and third stages are identical seven-tap half-band filters with the symmetric taps −1, 0, 9, 16, 9, 0, −1, scaled by 1/32.

A clock enable marks each modulator sample. Both channels share the phase counter and are filtered in the same way. After every 64th enabled sample the block registers one word per channel and pulses a valid strobe. A word that had to be clipped to the 16-bit range carries a per-channel overrange flag. Full scale is set so that a steady input density d gives the word (2d − 1) · 32768. A stream of all ones therefore sits one step above the positive rail and is clipped.

Top module: `bitstream_decimator`

## Requirements
- R1: `pcm_valid` is a one-cycle pulse. It rises on the clock after every 64th enabled sample counted from reset, and there is exactly one word for each 64 enabled samples.
- R2: A steady all-zeros input on a channel settles to −32768 (0x8000) with its overrange flag low.
- R3: A steady input whose ones density is d, with a period that divides 16, settles to exactly (2d − 1) · 32768: density 3/4 gives 16384, 1/2 gives 0 and 1/4 gives −16384.
- R4: A steady all-ones input settles to 32767 (0x7FFF) with that channel's overrange flag high, because the unclipped value 32768 is out of range.
- R5: The two channels are independent: different patterns on the left and right inputs give each channel its own settled value.
- R6: While `ce` is low the input bits are ignored, the words do not change and no valid pulse is produced.
- R7: After reset no valid pulse appears until the 8th frame. The first word arrives on the clock after the 512th enabled sample.
- R8: Reset clears both words to 0, both overrange flags to 0 and `pcm_valid` to 0.
- R9: The overrange flag belongs to each word. It goes low again on the first word that did not need clipping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Modulator sample enable (64 per output word) |
| bit_l | input | 1 | Left modulator bit |
| bit_r | input | 1 | Right modulator bit |
| pcm_l | output | 16 | Left signed PCM word |
| pcm_r | output | 16 | Right signed PCM word |
| pcm_valid | output | 1 | One-cycle strobe: new words present |
| ovr_l | output | 1 | Left word was clipped |
| ovr_r | output | 1 | Right word was clipped |

## Verification
A word and its flags are registered on the same edge that takes in the 64th enabled sample of a frame. The bench therefore looks for them at the falling edge that follows. It tags the first one seen with the running count of enabled samples, which must be 512. A new input pattern takes about seven frames to pass through all the delay lines. For that reason the bench holds each pattern for twelve frames and checks only the last word, by which time the response has settled to its exact value. Enable gaps stretch the frame in clock cycles but not in samples, so the word count and the settled values of a gapped run must match those of an ungapped one.

// File: rtl/bitstream_decimator.sv
module bitstream_decimator #(
  parameter int OW   = 16,
  parameter int AW   = 20,
  parameter int FILL = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ce,
  input  logic                 bit_l,
  input  logic                 bit_r,
  output logic signed [OW-1:0] pcm_l,
  output logic signed [OW-1:0] pcm_r,
  output logic                 pcm_valid,
  output logic                 ovr_l,
  output logic                 ovr_r
);
  localparam int ORDER = 4;
  localparam int L1    = 4;
  localparam int PW    = L1 + 2;
  localparam int HW    = AW + 4;
  localparam int TAPS  = 7;
  localparam int FW    = $clog2(FILL + 1);
  localparam logic signed [AW-1:0] STEP_UP = AW'(1);
  localparam logic signed [AW-1:0] STEP_DN = -AW'(1);
  localparam logic signed [HW-1:0] K9   = HW'(9);
  localparam logic signed [HW-1:0] HMAX = HW'(2**(OW-1) - 1);
  localparam logic signed [HW-1:0] HMIN = HW'(-(2**(OW-1)));

  logic [PW-1:0] ph;
  logic [FW-1:0] fcnt;
  logic t1, t2, t3, fire;

  assign t1   = ce && (ph[L1-1:0] == '1);
  assign t2   = ce && (ph[L1:0] == '1);
  assign t3   = ce && (ph == '1);
  assign fire = t3 && (fcnt >= FW'(FILL - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= '0;
      fcnt      <= '0;
      pcm_valid <= 1'b0;
    end else begin
      if (ce) ph <= ph + 1'b1;
      if (t3 && fcnt != FW'(FILL)) fcnt <= fcnt + 1'b1;
      pcm_valid <= fire;
    end
  end

  function automatic logic signed [HW-1:0] halfband(
    input logic signed [HW-1:0] a0, a2, a3, a4, a6);
    logic signed [HW-1:0] acc;
    acc = (a3 <<< 4) + (a2 + a4) * K9 - (a0 + a6);
    return acc >>> 5;
  endfunction

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    logic                 din;
    logic signed [AW-1:0] integ [ORDER];
    logic signed [AW-1:0] dly   [ORDER];
    logic signed [AW-1:0] cmb   [ORDER+1];
    logic signed [HW-1:0] x2    [TAPS];
    logic signed [HW-1:0] x3    [TAPS];
    logic signed [HW-1:0] h2, h3, y;
    logic signed [OW-1:0] w;
    logic                 c;

    assign din = (ch == 0) ? bit_l : bit_r;

    always_comb begin
      cmb[0] = integ[ORDER-1];
      for (int k = 0; k < ORDER; k++) cmb[k+1] = cmb[k] - dly[k];
    end

    assign h2 = halfband(x2[0], x2[2], x2[3], x2[4], x2[6]);
    assign h3 = halfband(x3[0], x3[2], x3[3], x3[4], x3[6]);
    assign y  = h3 >>> 1;

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int k = 0; k < ORDER; k++) begin
          integ[k] <= '0;
          dly[k]   <= '0;
        end
        for (int i = 0; i < TAPS; i++) begin
          x2[i] <= '0;
          x3[i] <= '0;
        end
        w <= '0;
        c <= 1'b0;
      end else begin
        if (ce) begin
          integ[0] <= integ[0] + (din ? STEP_UP : STEP_DN);
          for (int k = 1; k < ORDER; k++) integ[k] <= integ[k] + integ[k-1];
        end
        if (t1) begin
          for (int k = 0; k < ORDER; k++) dly[k] <= cmb[k];
          x2[0] <= HW'(cmb[ORDER]);
          for (int i = 1; i < TAPS; i++) x2[i] <= x2[i-1];
        end
        if (t2) begin
          x3[0] <= h2;
          for (int i = 1; i < TAPS; i++) x3[i] <= x3[i-1];
        end
        if (fire) begin
          if (y > HMAX) begin
            w <= HMAX[OW-1:0];
            c <= 1'b1;
          end else if (y < HMIN) begin
            w <= HMIN[OW-1:0];
            c <= 1'b1;
          end else begin
            w <= y[OW-1:0];
            c <= 1'b0;
          end
        end
      end
    end

    AST_CLIP_AT_RAIL: assert property (@(posedge clk) disable iff (rst)
      c |-> (w == HMAX[OW-1:0] || w == HMIN[OW-1:0])); // R4

    if (ch == 0) begin : g_left
      assign pcm_l = w;
      assign ovr_l = c;
    end else begin : g_right
      assign pcm_r = w;
      assign ovr_r = c;
    end
  end

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    pcm_valid |=> !pcm_valid); // R1

  AST_VALID_ON_FRAME: assert property (@(posedge clk) disable iff (rst)
    pcm_valid |-> ph == '0); // R1

  AST_HOLD_NO_CE: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(pcm_l) && $stable(pcm_r) && !pcm_valid)); // R6

  AST_QUIET_BEFORE_FILL: assert property (@(posedge clk) disable iff (rst)
    pcm_valid |-> fcnt == FW'(FILL)); // R7

endmodule

// File: tb/sim_bitstream_decimator.sv
`timescale 1ns/1ps
module sim_bitstream_decimator;
  logic clk = 1'b0;
  logic rst, ce, bit_l, bit_r;
  logic signed [15:0] pcm_l, pcm_r;
  logic pcm_valid, ovr_l, ovr_r;

  always #2.5 clk = ~clk;

  bitstream_decimator u0 (
    .clk(clk), .rst(rst), .ce(ce), .bit_l(bit_l), .bit_r(bit_r),
    .pcm_l(pcm_l), .pcm_r(pcm_r), .pcm_valid(pcm_valid),
    .ovr_l(ovr_l), .ovr_r(ovr_r)
  );

  int total = 0, bad = 0;
  int nval, ce_seen, first_ce;
  int last_l, last_r, last_ol, last_or;
  bit finished = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic capture();
    if (pcm_valid) begin
      nval++;
      last_l  = pcm_l;
      last_r  = pcm_r;
      last_ol = ovr_l;
      last_or = ovr_r;
      if (first_ce < 0) first_ce = ce_seen;
    end
  endtask

  task automatic run(input int frames, input logic [15:0] pl, input logic [15:0] pr, input bit gaps);
    int k = 0;
    int cyc = 0;
    nval = 0;
    while (k < frames * 64) begin
      @(negedge clk);
      capture();
      if (gaps && (cyc % 3 == 1)) begin
        ce = 1'b0;
        bit_l = ~bit_l;
        bit_r = ~bit_r;
      end else begin
        ce = 1'b1;
        bit_l = pl[k % 16];
        bit_r = pr[k % 16];
        k++;
        ce_seen++;
      end
      cyc++;
    end
    @(negedge clk);
    capture();
    ce = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; ce = 1'b0; bit_l = 1'b0; bit_r = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    ce_seen = 0;
    first_ce = -1;
    @(negedge clk);
    chk("R8 pcm_l", pcm_l, 0);
    chk("R8 pcm_r", pcm_r, 0);
    chk("R8 pcm_valid", pcm_valid, 0);
    chk("R8 ovr", ovr_l | ovr_r, 0);
  endtask

  task automatic t_fill_zeros();
    run(20, 16'h0000, 16'h0000, 1'b0);
    chk("R7 first word ce count", first_ce, 512);
    chk("R1 words in 20 frames", nval, 13);
    chk("R2 zeros left", last_l, -32768);
    chk("R2 zeros right", last_r, -32768);
    chk("R2 zeros overrange", last_ol | last_or, 0);
  endtask

  task automatic t_ones();
    run(12, 16'hFFFF, 16'hFFFF, 1'b0);
    chk("R1 words in 12 frames", nval, 12);
    chk("R4 ones left", last_l, 32767);
    chk("R4 ones right", last_r, 32767);
    chk("R4 ones overrange", last_ol & last_or, 1);
  endtask

  task automatic t_clear();
    run(12, 16'h5555, 16'h5555, 1'b0);
    chk("R3 half density", last_l, 0);
    chk("R9 overrange cleared left", last_ol, 0);
    chk("R9 overrange cleared right", last_or, 0);
  endtask

  task automatic t_mixed();
    run(12, 16'h7777, 16'h1111, 1'b0);
    chk("R3 three quarters left", last_l, 16384);
    chk("R5 one quarter right", last_r, -16384);
  endtask

  task automatic t_gaps();
    run(12, 16'h1111, 16'h7777, 1'b1);
    chk("R6 gapped words", nval, 12);
    chk("R6 gapped left", last_l, -16384);
    chk("R6 gapped right", last_r, 16384);
    chk("R5 gapped overrange", last_ol | last_or, 0);
  endtask

  initial begin
    t_reset();
    t_fill_zeros();
    t_ones();
    t_clear();
    t_mixed();
    t_gaps();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule